// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous static RAM with a shared data bus. It accepts a new command on every enabled clock edge. Reads and writes may follow each other in any order without idle bus cycles, because write data waits through the same two-edge pipeline that read data takes. Both kinds of transfer therefore use the same bus slot.

Each command is either loaded from the external address or made by stepping a four-word burst counter. The counter steps in linear or interleaved order. A clock enable freezes every register, and a synchronous write to the storage array is controlled per 9-bit lane.

The data bus comes out as an input half, an output half and a drive enable, ready for a pad tristate. The drive enable is registered, so it is off for every write slot, and an asynchronous output enable can force it off at any time. A read issued right after a write to the same word returns the new data, merged lane by lane, through a bypass path.

Top module: `zt_sram`

## Requirements
- R1: A read is loaded at an enabled edge k when `adv`=0, `wr_en`=0 and all three selects are active (`sel1_n`=0, `sel2`=1, `sel3_n`=0). Its word is on `dq_o`, with `dq_oe`=1, from enabled edge k+2 until the next enabled edge.
- R2: For a write loaded at edge k, the word is sampled from `dq_i` at enabled edge k+2. `byte_en[0]` (sampled at edge k) enables bits 8:0 and `byte_en[1]` enables bits 17:9. A disabled lane keeps its old contents.
- R3: Reads and writes can be issued back to back on every enabled edge. A read issued on the enabled edge right after a write to the same word returns that write's lanes merged over the stored word.
- R4: When `clk_en`=0, the edge is ignored. `dq_o` and `dq_oe` hold their values, and no stage, counter or array word changes.
- R5: A load cycle with any select inactive performs no access. Its data slot has `dq_oe`=0, and memory is unchanged.
- R6: In the data slot of every write, `dq_oe` is 0.
- R7: `out_en`=0 forces `dq_oe` to 0 at once, without waiting for a clock edge. It does not disturb the pipeline, so later reads return correct data.
- R8: With `adv`=1, only the low two address bits change. The upper bits stay those of the last load, and the command type of that load repeats. With `burst_ilv`=0, word n of the burst is at (start+n) mod 4. With `burst_ilv`=1, it is at start XOR n. After the fourth word, the sequence wraps to the starting word.
- R9: While `rst`=1, and after its first edge, `dq_oe` is 0 and the pipeline holds no access.
- R10: Advance cycles that follow a deselected load also perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock qualifier; 0 freezes all state |
| addr | input | ADDR_W | Word address, used on load cycles |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| wr_en | input | 1 | 1 = write, 0 = read (load cycles) |
| byte_en | input | LANES | Per-lane write enable |
| adv | input | 1 | 1 = step burst counter, 0 = load new command |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en | input | 1 | Asynchronous output enable, active high |
| dq_i | input | DATA_W | Data bus, inbound half |
| dq_o | output | DATA_W | Data bus, outbound half (registered) |
| dq_oe | output | 1 | Bus drive enable |

## Verification
On every cycle, the assertions check that bus drive is off in write and idle slots and on in read slots. They also check that `out_en` overrides drive, that a frozen edge leaves the output and the slot state unchanged, that an advance keeps the upper address bits, and that reset clears drive. Only the bench scenarios show that the data is correct. These cover the two-edge read and write alignment, lane masking, the same-word read-after-write merge, both burst orders with wrap, deselected loads and advances leaving memory untouched, and data surviving stalls inserted while a write is in flight.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  // command carried down the address/control pipeline
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/zt_burst_addr.sv
module zt_burst_addr #(
  parameter int ADDR_W  = 10,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    base_q;
  logic [BURST_W-1:0] start_q, cnt_q, nxt_cnt, nxt_low;

  assign nxt_cnt = cnt_q + BURST_W'(1);
  assign nxt_low = ilv ? (start_q ^ nxt_cnt) : BURST_W'(start_q + nxt_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      start_q  <= '0;
      cnt_q    <= '0;
      cur_addr <= '0;
    end else if (en) begin
      if (load) begin
        base_q   <= ld_addr[ADDR_W-1:BURST_W];
        start_q  <= ld_addr[BURST_W-1:0];
        cnt_q    <= '0;
        cur_addr <= ld_addr;
      end else begin
        cnt_q    <= nxt_cnt;
        cur_addr <= {base_q, nxt_low};
      end
    end
  end
endmodule

// File: rtl/zt_ram_core.sv
module zt_ram_core #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANE_W*LANES-1:0]  rd_data,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES-1:0]         wr_be,
  input  logic [LANE_W*LANES-1:0]  wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  // one narrow array per lane so each maps onto its own block RAM
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en) begin
        if (wr && wr_be[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        rd_q <= mem[rd_addr];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  byte_en,
  input  logic              adv,
  input  logic              burst_ilv,
  input  logic              out_en,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  logic        sel_all;
  sram_op_e    ld_op, op_a, op_b;
  logic [ADDR_W-1:0] addr_a, addr_b;
  logic [LANES-1:0]  be_a, be_b;
  logic [DATA_W-1:0] ram_q, merged;
  logic              byp_hit;
  logic [LANES-1:0]  byp_be;
  logic [DATA_W-1:0] byp_data;
  logic              drive_q;

  assign sel_all = !sel1_n && sel2 && !sel3_n;

  always_comb begin
    if (!sel_all)   ld_op = OP_IDLE;
    else if (wr_en) ld_op = OP_WRITE;
    else            ld_op = OP_READ;
  end

  // stage A address: loaded or stepped by the burst counter
  zt_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .en       (clk_en),
    .load     (!adv),
    .ilv      (burst_ilv),
    .ld_addr  (addr),
    .cur_addr (addr_a)
  );

  // command pipeline; an advance keeps the last loaded command type
  always_ff @(posedge clk) begin
    if (rst) begin
      op_a   <= OP_IDLE;
      op_b   <= OP_IDLE;
      be_a   <= '0;
      be_b   <= '0;
      addr_b <= '0;
    end else if (clk_en) begin
      if (!adv) op_a <= ld_op;
      be_a   <= byte_en;
      op_b   <= op_a;
      addr_b <= addr_a;
      be_b   <= be_a;
    end
  end

  // write commits at the edge its data arrives; read of stage A at same edge
  zt_ram_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_ram (
    .clk     (clk),
    .en      (clk_en),
    .rd_addr (addr_a),
    .rd_data (ram_q),
    .wr      (!rst && op_b == OP_WRITE),
    .wr_addr (addr_b),
    .wr_be   (be_b),
    .wr_data (dq_i)
  );

  // a read colliding with the write committing at the same edge
  always_ff @(posedge clk) begin
    if (rst)         byp_hit <= 1'b0;
    else if (clk_en) byp_hit <= (op_b == OP_WRITE) && (op_a == OP_READ) && (addr_a == addr_b);
  end

  always_ff @(posedge clk) begin
    if (clk_en) begin
      byp_be   <= be_b;
      byp_data <= dq_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (byp_hit && byp_be[g]) ?
                                        byp_data[g*LANE_W +: LANE_W] :
                                        ram_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o    <= '0;
      drive_q <= 1'b0;
    end else if (clk_en) begin
      dq_o    <= merged;
      drive_q <= (op_b == OP_READ);
    end
  end

  assign dq_oe = drive_q && out_en;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              adv,
  input logic              out_en,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_o,
  input sram_op_e          op_b,
  input logic [ADDR_W-1:0] addr_a
);
  // R1
  read_slot_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && op_b == OP_READ) |=> (dq_oe || !out_en));

  // R6
  write_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && op_b == OP_WRITE) |=> !dq_oe);

  // R5
  idle_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && op_b == OP_IDLE) |=> !dq_oe);

  // R4
  frozen_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(dq_o) && $stable(op_b)));

  // R7
  oe_override_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> !dq_oe);

  // R8
  burst_upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv) |=> (addr_a[ADDR_W-1:BURST_W] == $past(addr_a[ADDR_W-1:BURST_W])));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !dq_oe);
endmodule

bind zt_sram zt_sram_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .BURST_W(BURST_W)
) u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .adv(adv), .out_en(out_en),
  .dq_oe(dq_oe), .dq_o(dq_o), .op_b(op_b), .addr_a(addr_a)
);

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int AW = 10;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic wr_en = 1'b0, adv = 1'b0, burst_ilv = 1'b0, out_en = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] byte_en = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  always #5 clk = ~clk;

  zt_sram u_zt_sram (
    .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .wr_en(wr_en),
    .byte_en(byte_en), .adv(adv), .burst_ilv(burst_ilv), .out_en(out_en),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  typedef struct {
    int          kind;   // 0 idle, 1 read, 2 write
    logic [DW-1:0] data;
    string       req;
  } item_t;

  item_t exp_q[$];
  item_t p0, p1;
  int errors = 0;
  int checks = 0;
  bit oe_lvl = 1'b1;
  logic [DW-1:0] ref_mem [1<<AW];
  logic [AW-1:0] b_base;
  int b_start, b_cnt, b_kind;

  // driver: one call per clock; expected slot results go to the scoreboard
  task automatic cyc(input bit ce, input bit ld, input int desel, input bit wr,
                     input logic [AW-1:0] a, input logic [NL-1:0] be,
                     input logic [DW-1:0] wd, input bit ilv, input string req);
    logic [DW-1:0] h_o;
    logic          h_oe;
    item_t         it;
    logic [AW-1:0] ea;
    @(negedge clk);
    clk_en = ce; adv = !ld; wr_en = wr; addr = a; byte_en = be; burst_ilv = ilv;
    sel1_n = (desel == 1); sel2 = (desel != 2); sel3_n = (desel == 3);
    out_en = oe_lvl;
    dq_i = (ce && p1.kind == 2) ? p1.data : 18'h2A5A5;
    #1;
    h_o = dq_o; h_oe = dq_oe;
    @(posedge clk); #1;
    if (!ce) begin
      checks++;  // R4
      if (dq_o !== h_o || dq_oe !== h_oe) begin
        errors++;
        $display("FAIL R4 frozen edge: dq_o=%h oe=%b expected %h %b", dq_o, dq_oe, h_o, h_oe);
      end
    end else begin
      if (ld) begin
        b_base = a; b_start = int'(a[1:0]); b_cnt = 0;
        b_kind = (desel != 0) ? 0 : (wr ? 2 : 1);
        ea = a;
      end else begin
        b_cnt = (b_cnt + 1) % 4;
        ea = {b_base[AW-1:2], 2'(ilv ? (b_start ^ b_cnt) : (b_start + b_cnt) % 4)};
      end
      it.kind = b_kind;
      it.req  = (b_kind == 2) ? "R6" : req;
      it.data = '0;
      if (b_kind == 2) begin
        for (int l = 0; l < NL; l++)
          if (be[l]) ref_mem[ea][l*LW +: LW] = wd[l*LW +: LW];
        it.data = wd;
      end else if (b_kind == 1) begin
        it.data = ref_mem[ea];
      end
      exp_q.push_back(p1);
      p1 = p0;
      p0 = it;
    end
  endtask

  task automatic wr_w(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] be);
    cyc(1'b1, 1'b1, 0, 1'b1, a, be, d, 1'b0, "R2");
  endtask
  task automatic rd_w(input logic [AW-1:0] a, input string req);
    cyc(1'b1, 1'b1, 0, 1'b0, a, '0, '0, 1'b0, req);
  endtask
  task automatic step_w(input logic [DW-1:0] d, input logic [NL-1:0] be, input bit ilv, input string req);
    cyc(1'b1, 1'b0, 0, 1'b0, '0, be, d, ilv, req);
  endtask
  task automatic nop_w(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 2, 1'b0, '0, '0, '0, 1'b0, "R5");
  endtask
  task automatic stall_w(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 0, 1'b1, 10'h3FF, 2'b11, 18'h3F0F0, 1'b0, "R4");
  endtask

  // monitor: compare every completed data slot against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      while (exp_q.size() > 0) begin
        item_t it;
        bit    want_oe;
        it = exp_q.pop_front();
        want_oe = (it.kind == 1) && out_en;  // R7 when out_en is low
        checks++;
        if (dq_oe !== want_oe || (want_oe && dq_o !== it.data)) begin
          errors++;
          $display("FAIL %s (out_en=%b): dq_o=%h dq_oe=%b expected %h %b",
                   it.req, out_en, dq_o, dq_oe, it.data, want_oe);
        end
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    p0.kind = 0; p0.data = '0; p0.req = "R5";
    p1 = p0;
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R9 during reset
    if (dq_oe !== 1'b0) begin errors++; $display("FAIL R9 in reset: dq_oe=%b expected 0", dq_oe); end
    rst = 1'b0;
    nop_w(1);
    checks++;  // R9 after reset
    if (dq_oe !== 1'b0) begin errors++; $display("FAIL R9 after reset: dq_oe=%b expected 0", dq_oe); end

    // R2 / R1: plain writes then reads
    wr_w(10'h010, 18'h12345, 2'b11);
    wr_w(10'h011, 18'h0ABCD, 2'b11);
    wr_w(10'h012, 18'h3FFFF, 2'b11);
    wr_w(10'h013, 18'h00001, 2'b11);
    rd_w(10'h010, "R1"); rd_w(10'h011, "R1"); rd_w(10'h012, "R1"); rd_w(10'h013, "R1");

    // R3: back-to-back mix and same-word read right after write
    wr_w(10'h020, 18'h11111, 2'b11); rd_w(10'h010, "R3");
    wr_w(10'h021, 18'h22222, 2'b11); rd_w(10'h020, "R3"); rd_w(10'h021, "R3");
    wr_w(10'h030, 18'h15555, 2'b11); rd_w(10'h030, "R3");
    wr_w(10'h030, 18'h2AAAA, 2'b01); rd_w(10'h030, "R3");
    wr_w(10'h030, 18'h3C3C3, 2'b10); rd_w(10'h030, "R3");
    wr_w(10'h030, 18'h00000, 2'b00); rd_w(10'h030, "R2");
    nop_w(2);

    // R8: linear write burst from low bits 2, then single reads
    cyc(1'b1, 1'b1, 0, 1'b1, 10'h042, 2'b11, 18'h00100, 1'b0, "R8");
    step_w(18'h00101, 2'b11, 1'b0, "R8");
    step_w(18'h00102, 2'b11, 1'b0, "R8");
    step_w(18'h00103, 2'b11, 1'b0, "R8");
    rd_w(10'h040, "R8"); rd_w(10'h041, "R8"); rd_w(10'h042, "R8"); rd_w(10'h043, "R8");
    // R8: interleaved read burst from 1, plus a fifth step to show wrap
    cyc(1'b1, 1'b1, 0, 1'b0, 10'h041, '0, '0, 1'b1, "R8");
    step_w('0, '0, 1'b1, "R8"); step_w('0, '0, 1'b1, "R8");
    step_w('0, '0, 1'b1, "R8"); step_w('0, '0, 1'b1, "R8");
    // R8: interleaved write burst from 3, linear read burst from 1
    cyc(1'b1, 1'b1, 0, 1'b1, 10'h053, 2'b11, 18'h0A000, 1'b1, "R8");
    step_w(18'h0A001, 2'b11, 1'b1, "R8");
    step_w(18'h0A002, 2'b11, 1'b1, "R8");
    step_w(18'h0A003, 2'b11, 1'b1, "R8");
    cyc(1'b1, 1'b1, 0, 1'b0, 10'h051, '0, '0, 1'b0, "R8");
    step_w('0, '0, 1'b0, "R8"); step_w('0, '0, 1'b0, "R8"); step_w('0, '0, 1'b0, "R8");
    nop_w(2);

    // R5 / R10: deselected loads and advances write nothing
    cyc(1'b1, 1'b1, 2, 1'b1, 10'h010, 2'b11, 18'h3DEAD, 1'b0, "R5");
    cyc(1'b1, 1'b0, 0, 1'b1, 10'h010, 2'b11, 18'h3BEEF, 1'b0, "R10");
    cyc(1'b1, 1'b0, 0, 1'b1, 10'h010, 2'b11, 18'h3BEEF, 1'b0, "R10");
    cyc(1'b1, 1'b1, 1, 1'b1, 10'h011, 2'b11, 18'h3DEAD, 1'b0, "R5");
    cyc(1'b1, 1'b1, 3, 1'b1, 10'h011, 2'b11, 18'h3DEAD, 1'b0, "R5");
    rd_w(10'h010, "R5"); rd_w(10'h011, "R5"); rd_w(10'h013, "R10");
    nop_w(2);

    // R4: stalls inside a read stream and while a write is in flight
    rd_w(10'h012, "R4"); stall_w(3); rd_w(10'h013, "R4"); stall_w(1);
    wr_w(10'h060, 18'h13579, 2'b11); stall_w(2); rd_w(10'h060, "R4");
    stall_w(1); nop_w(1); stall_w(2); nop_w(2);

    // R7: output enable low hides read data; pipeline keeps working
    oe_lvl = 1'b0;
    rd_w(10'h010, "R7"); rd_w(10'h011, "R7"); nop_w(2);
    oe_lvl = 1'b1;
    rd_w(10'h010, "R7"); rd_w(10'h060, "R7");
    nop_w(3);

    @(negedge clk); #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule